// File: doc/BRIEF.md
# Interrupt Pending and Routing Controller

This block gathers sixteen interrupt request lines into one pending register and steers each source to one of two processor interrupt outputs. The outputs are a normal interrupt (`irq_o`) and a fast interrupt (`fiq_o`). Each source arrives as a single-cycle request pulse. The pulse sets a sticky pending flag, and the flag stays set until software clears it.

Software controls the block through a small register port. A per-source enable mask gates each pending flag before it reaches the outputs. A route mask sends each enabled source either to the normal line or to the fast line. Pending flags are cleared through a separate write-one-to-clear location. Three positions (10, 14 and 15) have no source behind them and stay zero in every register.

Both outputs are formed without a register stage from the stored flags and masks. A change in the flags or the masks therefore shows on the outputs in the cycle right after the clock edge that caused it.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, the enable mask, route mask and pending flags all read zero, and both `irq_o` and `fiq_o` are low. Every source therefore starts disabled and routed to the fast line.
- R2: A request pulse on a live bit of `req_i` sets that pending flag at the next clock edge. The flag reads back as 1 at address 0x108 until it is cleared.
- R3: Bits 10, 14 and 15 never set in the pending register, even when requested. They read as zero at every address.
- R4: A write to address 0x104 clears each pending flag whose data bit is 1. Flags whose data bit is 0 keep their value. The address 0x104 itself reads as zero.
- R5: When a new request and a clear hit the same bit in the same cycle, the request wins and the flag is set after that edge.
- R6: `irq_o` is high whenever at least one flag is pending and enabled with its route bit at 1 (route register at 0x10C).
- R7: `fiq_o` is high whenever at least one flag is pending and enabled with its route bit at 0.
- R8: A flag latches while its source is disabled and drives no output. Writing its enable bit at 0x100 raises the matching output in the cycle after the write.
- R9: The enable mask (0x100) and the route mask (0x10C) read back the written data with the reserved bits forced to zero. A write to 0x108 has no effect on the pending flags. Any other address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Single-cycle request pulses, one bit per source |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that `req_i` carries pulses that have already been edge-detected. They also assume that any register write is a single-cycle strobe with a stable address and stable data. They make no assumption about requests arriving on reserved bits, and the stimulus drives such requests on purpose to show that those bits stay at zero. The bench changes every input only on the falling clock edge and holds each strobe for exactly one rising edge. It also uses the same-cycle request-and-clear case deliberately, so that the precedence rule is exercised at a known edge.

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl #(
  parameter int NSRC = 16,
  parameter int AW   = 12,
  parameter logic [NSRC-1:0] LIVE  = 16'h3BFF,
  parameter logic [AW-1:0]   A_EN   = 12'h100,
  parameter logic [AW-1:0]   A_CLR  = 12'h104,
  parameter logic [AW-1:0]   A_PEND = 12'h108,
  parameter logic [AW-1:0]   A_SEL  = 12'h10C
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [NSRC-1:0] wr_data_i,
  output logic [NSRC-1:0] rd_data_o,
  output logic            irq_o,
  output logic            fiq_o
);

  logic [NSRC-1:0] pend_q, en_q, sel_q;
  logic [NSRC-1:0] clr_mask, hot;

  assign clr_mask = (wr_en_i && addr_i == A_CLR) ? wr_data_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      sel_q  <= '0;
    end else begin
      pend_q <= ((pend_q & ~clr_mask) | req_i) & LIVE;
      if (wr_en_i && addr_i == A_EN)  en_q  <= wr_data_i & LIVE;
      if (wr_en_i && addr_i == A_SEL) sel_q <= wr_data_i & LIVE;
    end
  end

  assign hot   = pend_q & en_q;
  assign irq_o = |(hot & sel_q);
  assign fiq_o = |(hot & ~sel_q);

  always_comb begin
    unique case (addr_i)
      A_EN:    rd_data_o = en_q;
      A_PEND:  rd_data_o = pend_q;
      A_SEL:   rd_data_o = sel_q;
      default: rd_data_o = '0;
    endcase
  end

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int NSRC = 16,
  parameter int AW   = 12,
  parameter logic [NSRC-1:0] LIVE  = 16'h3BFF,
  parameter logic [AW-1:0]   A_CLR = 12'h104
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] req_i,
  input logic [AW-1:0]   addr_i,
  input logic            wr_en_i,
  input logic [NSRC-1:0] wr_data_i,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] sel_q,
  input logic            irq_o,
  input logic            fiq_o
);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q | en_q | sel_q) & ~LIVE) == '0);

  // R5: this check also covers a clear that arrives in the same cycle as the request.
  p_req_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_i & LIVE)) |=> ((pend_q & $past(req_i & LIVE)) == $past(req_i & LIVE)));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == A_CLR) |=> ((pend_q & $past(wr_data_i & ~req_i)) == '0));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en_i && addr_i == A_CLR) && req_i == '0) |=> $stable(pend_q));

  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !fiq_o) |-> ((pend_q & en_q) == '0));

  p_irq_routed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sel_q != '0));

  p_fiq_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> (sel_q != LIVE));

endmodule

bind irq_route_ctrl irq_route_chk #(
  .NSRC(NSRC), .AW(AW), .LIVE(LIVE), .A_CLR(A_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .pend_q(pend_q),
  .en_q(en_q), .sel_q(sel_q), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_irq_route_ctrl.sv
module tb_irq_route_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] req_i = '0;
  logic [11:0] addr_i = '0;
  logic        wr_en_i = 0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        irq_o, fiq_o;
  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  localparam logic [11:0] A_EN = 12'h100, A_CLR = 12'h104, A_PEND = 12'h108, A_SEL = 12'h10C;

  // {req, enable, route, irq, fiq, pending}
  localparam int NV = 8;
  localparam logic [65:0] VEC [NV] = '{
    {16'h0001, 16'h0001, 16'h0001, 1'b1, 1'b0, 16'h0001},
    {16'h0001, 16'h0001, 16'h0000, 1'b0, 1'b1, 16'h0001},
    {16'h0400, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 16'h0000},
    {16'hC000, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 16'h0000},
    {16'h2080, 16'h2000, 16'h0080, 1'b0, 1'b1, 16'h2080},
    {16'h2080, 16'h2080, 16'h0080, 1'b1, 1'b1, 16'h2080},
    {16'h0810, 16'h0000, 16'hFFFF, 1'b0, 1'b0, 16'h0810},
    {16'h3BFF, 16'h0100, 16'h0100, 1'b1, 1'b0, 16'h3BFF}
  };

  irq_route_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    addr_i = a; wr_data_i = d; wr_en_i = 1;
    @(negedge clk);
    wr_en_i = 0; wr_data_i = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic pulse(input logic [15:0] r);
    @(negedge clk);
    req_i = r;
    @(negedge clk);
    req_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    rd(A_EN, rv);   chk("R1 enable", rv, 16'h0);
    rd(A_SEL, rv);  chk("R1 route", rv, 16'h0);
    rd(A_PEND, rv); chk("R1 pending", rv, 16'h0);
    chk("R1 outputs", {14'h0, irq_o, fiq_o}, 16'h0);

    // Vector walk: R2 R3 R6 R7
    for (int i = 0; i < NV; i++) begin
      wr(A_CLR, 16'hFFFF);
      wr(A_EN, VEC[i][49:34]);
      wr(A_SEL, VEC[i][33:18]);
      pulse(VEC[i][65:50]);
      rd(A_PEND, rv);
      chk("R2 R3 pending", rv, VEC[i][15:0]);
      chk("R6 irq", {15'h0, irq_o}, {15'h0, VEC[i][17]});
      chk("R7 fiq", {15'h0, fiq_o}, {15'h0, VEC[i][16]});
    end

    // R4: selective clear
    wr(A_CLR, 16'hFFFF);
    wr(A_EN, 16'h0000);
    pulse(16'h0003);
    wr(A_CLR, 16'h0001);
    rd(A_PEND, rv); chk("R4 selective clear", rv, 16'h0002);
    rd(A_CLR, rv);  chk("R4 clear reads zero", rv, 16'h0000);

    // R5: request beats clear in the same cycle
    wr(A_CLR, 16'hFFFF);
    pulse(16'h0020);
    @(negedge clk);
    req_i = 16'h0060; addr_i = A_CLR; wr_data_i = 16'h0060; wr_en_i = 1;
    @(negedge clk);
    req_i = '0; wr_en_i = 0; wr_data_i = '0;
    rd(A_PEND, rv); chk("R5 request wins", rv, 16'h0060);

    // R8: latch while disabled, enable raises output after the write
    wr(A_CLR, 16'hFFFF);
    wr(A_SEL, 16'h0200);
    wr(A_EN, 16'h0000);
    pulse(16'h0200);
    chk("R8 masked irq low", {15'h0, irq_o}, 16'h0);
    rd(A_PEND, rv); chk("R8 latched while disabled", rv, 16'h0200);
    wr(A_EN, 16'h0200);
    chk("R8 irq after enable", {15'h0, irq_o}, 16'h1);
    chk("R8 fiq stays low", {15'h0, fiq_o}, 16'h0);

    // R9: readback and read-only pending
    wr(A_EN, 16'hFFFF);
    rd(A_EN, rv);   chk("R9 enable readback", rv, 16'h3BFF);
    wr(A_SEL, 16'hA5A5);
    rd(A_SEL, rv);  chk("R9 route readback", rv, 16'hA5A5 & 16'h3BFF);
    wr(A_PEND, 16'hFFFF);
    rd(A_PEND, rv); chk("R9 pending read-only", rv, 16'h0200);
    rd(12'h200, rv); chk("R9 unmapped reads zero", rv, 16'h0000);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule